// File: doc/BRIEF.md
# Circular History Buffer with Triggered Multi-Slice Readout

The block keeps a rolling history of wide per-crossing records. Every cycle in which the record strobe is high, one 209-bit record is stored in a 512-entry circular dual-port memory. The write address runs a programmable distance ahead of a free-running crossing counter. That distance is the pipeline latency between a crossing and the arrival of its trigger decision.

When a trigger-accept pulse arrives, the block captures the crossing counter, the 4-bit trigger slice number and the 3-bit slice-count setting into a small pending queue. A read state machine takes pending triggers in arrival order. For each one it copies the requested number of consecutive history entries, starting at the triggered crossing, onto the write port of a downstream output FIFO. Each word carries the slice number captured with its trigger. Readout pauses whenever the downstream FIFO reports programmable-full. An 8-bit monitor exposes the machine state, the number of pending triggers and the slices still to be read.

Top module: `circ_hist_buffer`

## Requirements
- R1: After reset, fifo_wr_en is 0, state_mon is 0 and no trigger is pending.
- R2: At each clock edge where rec_strobe is 1, rec_data is stored at address (c + latency_preload) mod 512, where c is the number of earlier strobed edges. An edge with rec_strobe 0 stores nothing and does not advance c.
- R3: For a trigger accepted at an edge with strobe count c, slice j (from 0) returns the record stored under count c + j - latency_preload. The read address is c + j mod 512, so it wraps from 511 to 0.
- R4: The slice-count setting n (slice_cfg, 3 bits) gives n words for n = 1..7. A setting of 0 gives exactly one word.
- R5: Every word written to the FIFO carries on fifo_tag the 4-bit trig_slice value sampled at the edge that accepted its trigger.
- R6: With the block idle and prog-full low, the first word of a trigger is on the FIFO write port after the second edge following the accepting edge. Further slices follow on consecutive cycles.
- R7: Triggers accepted while a readout is active wait in a 4-entry queue and are served in arrival order. Each one uses its own captured start, slice count and tag, and none is lost.
- R8: An edge at which fifo_prog_full is 1 issues no memory read, so no word is written after the following edge. Readout resumes with the next slice once the flag clears, and no slice is skipped or repeated.
- R9: state_mon[1:0] holds the state code (idle 0, transfer 1, drain 2), state_mon[4:2] the number of pending triggers, and state_mon[7:5] the slices not yet read for the current trigger. The monitor is 0 when the block is idle with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_data | input | 209 | Record for the current crossing |
| rec_strobe | input | 1 | Store rec_data and advance the crossing count |
| trig_accept | input | 1 | Trigger-accept pulse, one cycle per trigger |
| trig_slice | input | 4 | Trigger slice number, captured on trig_accept |
| latency_preload | input | 9 | Distance of the write address ahead of the crossing count |
| slice_cfg | input | 3 | Number of slices per trigger (0 means 1), captured on trig_accept |
| fifo_prog_full | input | 1 | Downstream FIFO programmable-full flag |
| fifo_wr_en | output | 1 | Write strobe to the downstream FIFO |
| fifo_wdata | output | 209 | Record read from history |
| fifo_tag | output | 4 | Trigger slice number belonging to fifo_wdata |
| state_mon | output | 8 | Monitor: remaining slices, pending count, state code |

## Verification
On every cycle, the embedded assertions check the following: the crossing count holds on unstrobed cycles, a stalled transfer keeps its remaining count and produces no write, the read address steps by one with wrap on each issued read, a popped trigger always yields at least one slice, the drain state returns to idle, and the pending queue is never pushed while full. Whether the right records come out cannot be shown by these local properties. That covers the latency offset, wrap across address 511, tag pairing, queue ordering across back-to-back triggers, and the exact first-word latency. Only the bench scenarios show them, by comparing every FIFO word against records the bench generated from its own crossing count.

// File: rtl/circ_hist_pkg.sv
package circ_hist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WAIT = 2'd2
    } rd_state_e;

endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
    parameter int DATA_W = 209,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hist_trig_queue.sv
module hist_trig_queue #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          din,
    input  logic                       pop,
    output logic                       valid,
    output logic [DATA_W-1:0]          dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } q_state_t;

    q_state_t          s_d, s_q;
    logic [DATA_W-1:0] slot_q [DEPTH];
    logic              do_pop;

    assign do_pop = pop && (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.wptr = (s_q.wptr == PTR_W'(DEPTH-1)) ? '0 : s_q.wptr + 1'b1;
        end
        if (do_pop) begin
            s_d.rptr = (s_q.rptr == PTR_W'(DEPTH-1)) ? '0 : s_q.rptr + 1'b1;
        end
        case ({push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[s_q.wptr] <= din;
        end
    end

    assign valid = (s_q.cnt != '0);
    assign dout  = slot_q[s_q.rptr];
    assign count = s_q.cnt;

    // R7: a trigger must never arrive while every slot is taken
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_W'(DEPTH) && !do_pop) |-> !push);

    // R7: occupancy follows pushes and pops one for one
    assert_count_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !do_pop) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));

endmodule

// File: rtl/hist_rd_fsm.sv
module hist_rd_fsm
    import circ_hist_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int SLC_W  = 3,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [TAG_W-1:0]  q_tag,
    input  logic [SLC_W-1:0]  q_nslc,
    output logic              q_pop,
    input  logic              prog_full,
    output logic              ram_re,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output rd_state_e         state,
    output logic [SLC_W-1:0]  remaining
);
    typedef struct packed {
        rd_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [SLC_W-1:0]  rem;
        logic [TAG_W-1:0]  tag;
        logic              issue;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.issue = 1'b0;
        q_pop     = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (q_valid) begin
                    q_pop    = 1'b1;
                    s_d.addr = q_addr;
                    s_d.rem  = (q_nslc == '0) ? SLC_W'(1) : q_nslc;
                    s_d.tag  = q_tag;
                    s_d.st   = ST_XFER;
                end
            end
            ST_XFER: begin
                if (!prog_full) begin
                    s_d.issue = 1'b1;
                    s_d.addr  = s_q.addr + 1'b1;
                    s_d.rem   = s_q.rem - 1'b1;
                    if (s_q.rem == SLC_W'(1)) begin
                        s_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ram_re    = s_d.issue;
    assign ram_raddr = s_q.addr;
    assign out_valid = s_q.issue;
    assign out_tag   = s_q.tag;
    assign state     = s_q.st;
    assign remaining = s_q.rem;

    // R8: a stalled transfer keeps its count and writes nothing next cycle
    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_XFER && prog_full) |=> (s_q.rem == $past(s_q.rem) && !out_valid));

    // R3: each issued read moves to the next address, wrapping at the top
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_XFER && !prog_full) |=> (s_q.addr == $past(s_q.addr) + 1'b1));

    // R4: a popped trigger always owes at least one slice
    assert_min_one_slice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && q_valid) |=> (s_q.st == ST_XFER && s_q.rem != '0));

    // R9: the drain state lasts exactly one cycle
    assert_drain_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT) |=> (s_q.st == ST_IDLE));

endmodule

// File: rtl/circ_hist_buffer.sv
module circ_hist_buffer
    import circ_hist_pkg::*;
#(
    parameter int REC_W  = 209,
    parameter int ADDR_W = 9,
    parameter int SLC_W  = 3,
    parameter int TAG_W  = 4,
    parameter int QDEPTH = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [REC_W-1:0]                        rec_data,
    input  logic                                    rec_strobe,
    input  logic                                    trig_accept,
    input  logic [TAG_W-1:0]                        trig_slice,
    input  logic [ADDR_W-1:0]                       latency_preload,
    input  logic [SLC_W-1:0]                        slice_cfg,
    input  logic                                    fifo_prog_full,
    output logic                                    fifo_wr_en,
    output logic [REC_W-1:0]                        fifo_wdata,
    output logic [TAG_W-1:0]                        fifo_tag,
    output logic [SLC_W+$clog2(QDEPTH+1)+1:0]       state_mon
);
    localparam int QCW   = $clog2(QDEPTH+1);
    localparam int ENT_W = ADDR_W + TAG_W + SLC_W;

    logic [ADDR_W-1:0] hist_ptr_d, hist_ptr_q;
    logic [ADDR_W-1:0] wr_addr;

    always_comb begin
        hist_ptr_d = hist_ptr_q;
        if (rec_strobe) begin
            hist_ptr_d = hist_ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_ptr_q <= '0;
        end else begin
            hist_ptr_q <= hist_ptr_d;
        end
    end

    assign wr_addr = hist_ptr_q + latency_preload;

    // R2: the crossing count only advances on strobed cycles
    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_strobe |=> $stable(hist_ptr_q));

    logic              q_valid, q_pop;
    logic [ENT_W-1:0]  q_dout;
    logic [QCW-1:0]    q_count;
    logic              ram_re;
    logic [ADDR_W-1:0] ram_raddr;
    rd_state_e         rd_state;
    logic [SLC_W-1:0]  rd_rem;

    hist_trig_queue #(
        .DATA_W (ENT_W),
        .DEPTH  (QDEPTH)
    ) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (trig_accept),
        .din   ({hist_ptr_q, trig_slice, slice_cfg}),
        .pop   (q_pop),
        .valid (q_valid),
        .dout  (q_dout),
        .count (q_count)
    );

    hist_rd_fsm #(
        .ADDR_W (ADDR_W),
        .SLC_W  (SLC_W),
        .TAG_W  (TAG_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_valid   (q_valid),
        .q_addr    (q_dout[ENT_W-1 -: ADDR_W]),
        .q_tag     (q_dout[SLC_W +: TAG_W]),
        .q_nslc    (q_dout[SLC_W-1:0]),
        .q_pop     (q_pop),
        .prog_full (fifo_prog_full),
        .ram_re    (ram_re),
        .ram_raddr (ram_raddr),
        .out_valid (fifo_wr_en),
        .out_tag   (fifo_tag),
        .state     (rd_state),
        .remaining (rd_rem)
    );

    hist_ram #(
        .DATA_W (REC_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .we    (rec_strobe),
        .waddr (wr_addr),
        .wdata (rec_data),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (fifo_wdata)
    );

    assign state_mon = {rd_rem, q_count, rd_state};

endmodule

// File: tb/tb_circ_hist_buffer.sv
module tb_circ_hist_buffer;

    localparam int PRE = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [208:0] rec_data = '0;
    logic         rec_strobe = 1'b0;
    logic         trig_accept = 1'b0;
    logic [3:0]   trig_slice = '0;
    logic [8:0]   latency_preload = 9'(PRE);
    logic [2:0]   slice_cfg = '0;
    logic         fifo_prog_full = 1'b0;
    logic         fifo_wr_en;
    logic [208:0] fifo_wdata;
    logic [3:0]   fifo_tag;
    logic [7:0]   state_mon;

    always #2.5 clk = ~clk;

    circ_hist_buffer dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .rec_data        (rec_data),
        .rec_strobe      (rec_strobe),
        .trig_accept     (trig_accept),
        .trig_slice      (trig_slice),
        .latency_preload (latency_preload),
        .slice_cfg       (slice_cfg),
        .fifo_prog_full  (fifo_prog_full),
        .fifo_wr_en      (fifo_wr_en),
        .fifo_wdata      (fifo_wdata),
        .fifo_tag        (fifo_tag),
        .state_mon       (state_mon)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int exp_k   [0:511];
    int exp_tag [0:511];
    int exp_wr = 0;
    int exp_rd = 0;
    bit done = 0;

    function automatic logic [208:0] pat(int k);
        logic [15:0] kk;
        kk = k[15:0];
        return {kk[0], {13{kk ^ 16'hA5C3}}};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // stimulus side: record content follows the bench's own strobe count
    always @(posedge clk) if (rec_strobe) wr_cnt <= wr_cnt + 1;
    always @(negedge clk) rec_data = pat(wr_cnt);

    // FIFO port monitor: every word against the expected record and tag
    always @(negedge clk) begin
        if (rst_n && fifo_wr_en) begin
            if (exp_rd >= exp_wr) begin
                check(1'b0, "R7", "unexpected word", 1, 0);
            end else begin
                check(fifo_wdata == pat(exp_k[exp_rd]), "R3", "slice record",
                      longint'(fifo_wdata[15:0]), longint'(pat(exp_k[exp_rd]) & 16'hFFFF));
                check(fifo_tag == 4'(exp_tag[exp_rd]), "R5", "slice tag",
                      longint'(fifo_tag), longint'(exp_tag[exp_rd]));
                exp_rd++;
            end
        end
    end

    task automatic fire(input int nslc, input int tag);
        int n;
        @(negedge clk);
        trig_accept = 1'b1;
        slice_cfg   = 3'(nslc);
        trig_slice  = 4'(tag);
        n = (nslc == 0) ? 1 : nslc;
        for (int j = 0; j < n; j++) begin
            exp_k[exp_wr]   = wr_cnt + j - PRE;
            exp_tag[exp_wr] = tag;
            exp_wr++;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        trig_accept = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic drain(input string req);
        idle(30);
        check(exp_rd == exp_wr, req, "words delivered", exp_rd, exp_wr);
        check(state_mon == 8'h00, "R9", "idle monitor", state_mon, 0);
    endtask

    // {slice setting[10:8], tag[7:4], gap[3:0]}
    localparam logic [10:0] VEC [8] = '{
        {3'd1, 4'h3, 4'd12},
        {3'd0, 4'h5, 4'd12},
        {3'd7, 4'hA, 4'd12},
        {3'd4, 4'h1, 4'd0},
        {3'd2, 4'h2, 4'd0},
        {3'd3, 4'hF, 4'd12},
        {3'd5, 4'h6, 4'd1},
        {3'd6, 4'h9, 4'd14}
    };

    initial begin
        int base;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(fifo_wr_en == 1'b0, "R1", "wr_en in reset", fifo_wr_en, 0);
        check(state_mon == 8'h00, "R1", "monitor in reset", state_mon, 0);
        rst_n = 1'b1;
        rec_strobe = 1'b1;
        repeat (2) @(negedge clk);
        check(fifo_wr_en == 1'b0 && state_mon == 8'h00, "R1", "after reset",
              {fifo_wr_en, state_mon}, 0);

        repeat (600) @(negedge clk);

        // table walk: R3 R4 R5 R7 (gap 0 gives back-to-back queued triggers)
        for (int v = 0; v < 8; v++) begin
            fire(int'(VEC[v][10:8]), int'(VEC[v][7:4]));
            if (VEC[v][3:0] != 0) idle(int'(VEC[v][3:0]));
        end
        drain("R7");

        // R4: setting 0 yields exactly one word
        base = exp_wr;
        fire(0, 4'hE);
        drain("R4");
        check(exp_wr - base == 1, "R4", "zero setting count", exp_wr - base, 1);

        // R6: first word appears after the second edge past the accepting edge
        fire(2, 4'h7);
        @(negedge clk); trig_accept = 1'b0;
        check(fifo_wr_en == 1'b0, "R6", "wr_en one edge after", fifo_wr_en, 0);
        @(negedge clk);
        check(fifo_wr_en == 1'b0, "R6", "wr_en two edges after", fifo_wr_en, 0);
        @(negedge clk);
        check(fifo_wr_en == 1'b1, "R6", "first word timing", fifo_wr_en, 1);
        @(negedge clk);
        check(fifo_wr_en == 1'b1, "R6", "second slice back to back", fifo_wr_en, 1);
        drain("R6");

        // R3: read addresses wrap from 511 to 0
        while ((wr_cnt % 512) != 508) @(negedge clk);
        fire(7, 4'hB);
        drain("R3");

        // R2: unstrobed cycles store nothing and hold the count
        @(negedge clk); rec_strobe = 1'b0;
        repeat (5) @(negedge clk);
        fire(3, 4'h4);
        idle(2);
        rec_strobe = 1'b1;
        drain("R2");

        // R8 + R9: prog-full held before the trigger blocks all reads
        @(negedge clk); fifo_prog_full = 1'b1;
        fire(5, 4'hC);
        idle(3);
        check(state_mon == 8'hA1, "R9", "stalled monitor", state_mon, 8'hA1);
        base = exp_rd;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(fifo_wr_en == 1'b0, "R8", "no write while full", fifo_wr_en, 0);
        end
        fifo_prog_full = 1'b0;
        drain("R8");
        check(exp_rd - base == 5, "R8", "all slices after stall", exp_rd - base, 5);

        // R8: stall in the middle of a transfer
        fire(7, 4'h8);
        @(negedge clk); trig_accept = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(fifo_wr_en == 1'b1, "R8", "word before stall", fifo_wr_en, 1);
        fifo_prog_full = 1'b1;
        @(negedge clk);
        check(fifo_wr_en == 1'b0, "R8", "stall takes effect", fifo_wr_en, 0);
        @(negedge clk);
        check(state_mon == 8'hC1, "R9", "mid-stall monitor", state_mon, 8'hC1);
        check(fifo_wr_en == 1'b0, "R8", "still stalled", fifo_wr_en, 0);
        fifo_prog_full = 1'b0;
        drain("R8");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule